// File: doc/BRIEF.md
# Control Transfer Privilege Checker

This block judges a far jump or far call before the control transfer starts. It is given the current privilege level, the selector named by the instruction, the instruction's offset and the descriptor that the selector picks. That descriptor may be a code segment, a call gate, a task gate or a task state descriptor. When the descriptor is a gate, the block is also given a second descriptor: the code segment that a call gate leads to, or the task state descriptor that a task gate leads to.

From these inputs it decides whether the transfer is allowed. It reports the kind of transfer: direct, through a gate at the same level, through a gate to a more privileged level, or a task switch. It also reports the privilege level that results, the new code selector, the entry offset and the number of parameter dwords a call gate asks to be copied. A raised stack-switch flag tells the following pipeline stage to change to the stack of the new level.

The decision is registered. A request presented on one clock edge is answered on the outputs after that edge. Stack switching, saving and loading task state, and the parameter copy itself belong to other blocks.

Top module: `ctpc_xfer_check`

## Requirements
- R1: A request sampled with `req_valid` high at a rising clock edge is answered after that edge, with `rsp_valid` high for exactly one cycle. With `req_valid` low, `rsp_valid` goes low and every result output keeps its value. After reset, `rsp_valid`, `allow` and all result outputs are zero.
- R2: Descriptor fields live in the upper word: present = bit 47, DPL = bits 46:45, S = bit 44, type = bits 43:40. A code segment has S=1 and type bit 3 set, and type bit 2 marks it conforming. A call gate has S=0 and type bits 2:0 = 100, and type bit 3 selects a 32-bit gate. A task gate has S=0 and type 0101. A task state descriptor has S=0, type bit 2 clear and type bit 0 set, and type bit 1 is its busy flag. Any other first descriptor gives fault code 2 (type).
- R3: A clear present bit, on the first descriptor or on a gate's second descriptor, gives fault code 3 (absent), separate from a privilege fault.
- R4: A direct transfer to a non-conforming code segment is allowed only when its DPL equals the CPL, and otherwise gives fault code 1 (privilege). On success: kind 0 (direct), new CPL = CPL, entry offset = the request offset, new code selector = request selector with its low two bits replaced by the CPL, parameter count 0.
- R5: A direct transfer to a conforming code segment is allowed when its DPL is less than or equal to the CPL, and the CPL stays unchanged. Otherwise it gives fault code 1.
- R6: Through a call gate, with EPL = max(CPL, request selector bits 1:0), the gate DPL must be at least EPL (otherwise fault 1). The second descriptor must be a code segment (otherwise fault 2) and present (otherwise fault 3). Its DPL must be at most EPL and at most CPL (otherwise fault 1).
- R7: After an allowed call gate transfer, the new CPL is the target DPL for a non-conforming target and the CPL for a conforming target. Kind is 2 (inner) with `stack_switch` high when the new CPL is below the CPL, and kind 1 (same level) otherwise.
- R8: The entry offset of a call gate is {bits 63:48, bits 15:0} for a 32-bit gate, and {16'h0, bits 15:0} for a 16-bit gate. The parameter count is bits 36:32. The new code selector is gate bits 31:18 followed by the new CPL, so the RPL bits 17:16 of the gate's selector have no effect.
- R9: A direct transfer to a task state descriptor is allowed only when CPL equals its DPL (otherwise fault 1). When that descriptor is busy, the transfer gives fault code 4 (busy). On success: kind 3, new CPL = CPL, offset, count and selector zero.
- R10: Through a task gate, only EPL ≤ gate DPL is checked for privilege, and the task state descriptor's DPL is ignored. The second descriptor must be a task state descriptor (otherwise fault 2), present (otherwise fault 3) and not busy (otherwise fault 4). On success, the outputs are the same as in R9.
- R11: When several faults apply, the one reported follows this priority: first-descriptor type, then first-descriptor presence, then gate privilege, then second-descriptor type, then second-descriptor presence, then target privilege or busy.
- R12: On any fault, `allow` is 0, kind is 0, new CPL = CPL, `stack_switch` is 0, and entry offset, parameter count and new code selector are zero. On success, the fault code is 0 and `allow` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| cur_cpl | input | 2 | Current privilege level |
| req_sel | input | 16 | Selector named by the instruction (bits 1:0 are the RPL) |
| req_off | input | 32 | Offset named by the instruction |
| desc_pri | input | 64 | Descriptor picked by `req_sel` |
| desc_tgt | input | 64 | Descriptor a gate leads to (ignored otherwise) |
| rsp_valid | output | 1 | Result valid |
| allow | output | 1 | Transfer allowed |
| fault_code | output | 3 | 0 none, 1 privilege, 2 type, 3 absent, 4 busy |
| xfer_kind | output | 2 | 0 direct, 1 gate same level, 2 gate inner, 3 task switch |
| new_cpl | output | 2 | Privilege level after the transfer |
| stack_switch | output | 1 | Stack of the new level must be loaded |
| entry_off | output | 32 | Entry offset |
| param_cnt | output | 5 | Parameter dwords to copy |
| new_cs_sel | output | 16 | New code selector |

## Verification
The bench sweeps every combination of CPL, RPL and the descriptor privilege levels for each of the four descriptor classes, plus all sixteen system types. This catches three errors. A design that compared against the CPL alone instead of max(CPL, RPL) would let a low-privilege requestor through a gate. One that read conforming as "DPL must equal CPL" would refuse calls into shared more-privileged code. One that checked the task state DPL behind a task gate would reject legal task switches.

The sweep also covers several other corner cases:
- Gate targets whose DPL lies between CPL and EPL: a design that trusted EPL alone would report an outward transfer as same level.
- 16-bit gates: a design that kept the upper offset half would give the wrong entry point.
- Gate selectors with nonzero RPL bits: a design that passed them into the new code selector would give the wrong CPL.
- Busy task state descriptors and descriptors with more than one fault: a design with a wrong fault priority would report the wrong code.

// File: rtl/ctpc_pkg.sv
package ctpc_pkg;

  localparam int PL_W     = 2;
  localparam int SEL_W    = 16;
  localparam int OFF_W    = 32;
  localparam int CNT_W    = 5;
  localparam int DESC_W   = 64;
  localparam int HALF_W   = OFF_W / 2;
  localparam int TYPE_W   = 4;
  localparam int FAULT_W  = 3;
  localparam int KIND_W   = 2;
  localparam int NUM_DESC = 2;

  // upper-word field positions
  localparam int P_BIT    = 47;
  localparam int DPL_LSB  = 45;
  localparam int S_BIT    = 44;
  localparam int TYPE_LSB = 40;
  localparam int CNT_LSB  = 32;
  localparam int GSEL_LSB = 16;

  typedef enum logic [KIND_W-1:0] {
    XK_DIRECT     = 2'd0,
    XK_GATE_SAME  = 2'd1,
    XK_GATE_INNER = 2'd2,
    XK_TASK       = 2'd3
  } xfer_kind_e;

  typedef enum logic [FAULT_W-1:0] {
    FC_NONE   = 3'd0,
    FC_PRIV   = 3'd1,
    FC_TYPE   = 3'd2,
    FC_ABSENT = 3'd3,
    FC_BUSY   = 3'd4
  } fault_e;

  typedef struct packed {
    logic              present;
    logic [PL_W-1:0]   dpl;
    logic              is_code;
    logic              conforming;
    logic              is_call_gate;
    logic              is_task_gate;
    logic              is_tss;
    logic              busy;
    logic [SEL_W-1:0]  gate_sel;
    logic [OFF_W-1:0]  gate_off;
    logic [CNT_W-1:0]  dword_cnt;
  } desc_info_t;

  typedef struct packed {
    logic              allow;
    fault_e            fault;
    xfer_kind_e        kind;
    logic [PL_W-1:0]   new_cpl;
    logic              stack_sw;
    logic [OFF_W-1:0]  entry_off;
    logic [CNT_W-1:0]  param_cnt;
    logic [SEL_W-1:0]  new_cs;
  } xfer_result_t;

  function automatic xfer_result_t fault_result(input fault_e f, input logic [PL_W-1:0] cpl);
    xfer_result_t r;
    r         = '0;
    r.fault   = f;
    r.kind    = XK_DIRECT;
    r.new_cpl = cpl;
    r.allow   = (f == FC_NONE);
    return r;
  endfunction

endpackage

// File: rtl/ctpc_desc_decode.sv
module ctpc_desc_decode
  import ctpc_pkg::*;
(
  input  logic [DESC_W-1:0] desc,
  output desc_info_t        info
);

  logic [TYPE_W-1:0] typ;
  logic              sys_n;

  assign typ   = desc[TYPE_LSB +: TYPE_W];
  assign sys_n = desc[S_BIT];

  always_comb begin
    info              = '0;
    info.present      = desc[P_BIT];
    info.dpl          = desc[DPL_LSB +: PL_W];
    info.is_code      = sys_n && typ[3];
    info.conforming   = typ[2];
    info.is_call_gate = !sys_n && (typ[2:0] == 3'b100);
    info.is_task_gate = !sys_n && (typ == 4'b0101);
    info.is_tss       = !sys_n && !typ[2] && typ[0];
    info.busy         = typ[1];
    info.gate_sel     = desc[GSEL_LSB +: SEL_W];
    info.dword_cnt    = desc[CNT_LSB +: CNT_W];
    if (typ[3]) begin
      info.gate_off = {desc[DESC_W-1 -: HALF_W], desc[HALF_W-1:0]};
    end else begin
      info.gate_off = {{HALF_W{1'b0}}, desc[HALF_W-1:0]};
    end
  end

endmodule

// File: rtl/ctpc_direct_eval.sv
module ctpc_direct_eval
  import ctpc_pkg::*;
(
  input  logic [PL_W-1:0]  cpl,
  input  logic [SEL_W-1:0] req_sel,
  input  logic [OFF_W-1:0] req_off,
  input  desc_info_t       pri,
  output xfer_result_t     res
);

  logic code_priv_ok;
  logic tss_priv_ok;

  assign code_priv_ok = pri.conforming ? (pri.dpl <= cpl) : (pri.dpl == cpl);
  assign tss_priv_ok  = (pri.dpl == cpl);

  always_comb begin
    res = fault_result(FC_NONE, cpl);
    if (pri.is_code) begin
      if (!pri.present) begin
        res = fault_result(FC_ABSENT, cpl);
      end else if (!code_priv_ok) begin
        res = fault_result(FC_PRIV, cpl);
      end else begin
        res.kind      = XK_DIRECT;
        res.entry_off = req_off;
        res.new_cs    = {req_sel[SEL_W-1:PL_W], cpl};
      end
    end else if (pri.is_tss) begin
      if (!pri.present) begin
        res = fault_result(FC_ABSENT, cpl);
      end else if (!tss_priv_ok) begin
        res = fault_result(FC_PRIV, cpl);
      end else if (pri.busy) begin
        res = fault_result(FC_BUSY, cpl);
      end else begin
        res.kind = XK_TASK;
      end
    end else begin
      res = fault_result(FC_TYPE, cpl);
    end
  end

endmodule

// File: rtl/ctpc_gate_eval.sv
module ctpc_gate_eval
  import ctpc_pkg::*;
(
  input  logic [PL_W-1:0] cpl,
  input  logic [PL_W-1:0] rpl,
  input  desc_info_t      gate,
  input  desc_info_t      tgt,
  output xfer_result_t    res
);

  logic [PL_W-1:0] epl;
  logic [PL_W-1:0] lvl_next;
  logic            gate_priv_ok;
  logic            tgt_priv_ok;
  logic            goes_inner;

  assign epl          = (rpl > cpl) ? rpl : cpl;
  assign gate_priv_ok = (epl <= gate.dpl);
  // target never less privileged than the caller, nor than the requestor
  assign tgt_priv_ok  = (tgt.dpl <= epl) && (tgt.dpl <= cpl);
  assign lvl_next     = tgt.conforming ? cpl : tgt.dpl;
  assign goes_inner   = (lvl_next < cpl);

  always_comb begin
    res = fault_result(FC_NONE, cpl);
    if (gate.is_call_gate) begin
      if (!gate.present) begin
        res = fault_result(FC_ABSENT, cpl);
      end else if (!gate_priv_ok) begin
        res = fault_result(FC_PRIV, cpl);
      end else if (!tgt.is_code) begin
        res = fault_result(FC_TYPE, cpl);
      end else if (!tgt.present) begin
        res = fault_result(FC_ABSENT, cpl);
      end else if (!tgt_priv_ok) begin
        res = fault_result(FC_PRIV, cpl);
      end else begin
        res.kind      = goes_inner ? XK_GATE_INNER : XK_GATE_SAME;
        res.new_cpl   = lvl_next;
        res.stack_sw  = goes_inner;
        res.entry_off = gate.gate_off;
        res.param_cnt = gate.dword_cnt;
        res.new_cs    = {gate.gate_sel[SEL_W-1:PL_W], lvl_next};
      end
    end else if (gate.is_task_gate) begin
      if (!gate.present) begin
        res = fault_result(FC_ABSENT, cpl);
      end else if (!gate_priv_ok) begin
        res = fault_result(FC_PRIV, cpl);
      end else if (!tgt.is_tss) begin
        res = fault_result(FC_TYPE, cpl);
      end else if (!tgt.present) begin
        res = fault_result(FC_ABSENT, cpl);
      end else if (tgt.busy) begin
        res = fault_result(FC_BUSY, cpl);
      end else begin
        res.kind = XK_TASK;
      end
    end else begin
      res = fault_result(FC_TYPE, cpl);
    end
  end

endmodule

// File: rtl/ctpc_xfer_check.sv
module ctpc_xfer_check
  import ctpc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        cur_cpl,
  input  logic [15:0]       req_sel,
  input  logic [31:0]       req_off,
  input  logic [63:0]       desc_pri,
  input  logic [63:0]       desc_tgt,
  output logic              rsp_valid,
  output logic              allow,
  output logic [2:0]        fault_code,
  output logic [1:0]        xfer_kind,
  output logic [1:0]        new_cpl,
  output logic              stack_switch,
  output logic [31:0]       entry_off,
  output logic [4:0]        param_cnt,
  output logic [15:0]       new_cs_sel
);

  logic [DESC_W-1:0] raw_desc [NUM_DESC];
  desc_info_t        info     [NUM_DESC];

  assign raw_desc[0] = desc_pri;
  assign raw_desc[1] = desc_tgt;

  for (genvar g = 0; g < NUM_DESC; g++) begin : g_dec
    ctpc_desc_decode u_dec (
      .desc (raw_desc[g]),
      .info (info[g])
    );
  end

  xfer_result_t res_direct;
  xfer_result_t res_gate;
  xfer_result_t res_sel;
  xfer_result_t res_d;
  xfer_result_t res_q;
  logic         vld_q;

  ctpc_direct_eval u_direct (
    .cpl     (cur_cpl),
    .req_sel (req_sel),
    .req_off (req_off),
    .pri     (info[0]),
    .res     (res_direct)
  );

  ctpc_gate_eval u_gate (
    .cpl  (cur_cpl),
    .rpl  (req_sel[PL_W-1:0]),
    .gate (info[0]),
    .tgt  (info[1]),
    .res  (res_gate)
  );

  always_comb begin
    if (info[0].is_call_gate || info[0].is_task_gate) begin
      res_sel = res_gate;
    end else begin
      res_sel = res_direct;
    end
  end

  // next state: capture only when a request is present
  always_comb begin
    res_d = res_q;
    if (req_valid) begin
      res_d = res_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      res_q <= res_d;
      vld_q <= req_valid;
    end
  end

  assign rsp_valid    = vld_q;
  assign allow        = res_q.allow;
  assign fault_code   = res_q.fault;
  assign xfer_kind    = res_q.kind;
  assign new_cpl      = res_q.new_cpl;
  assign stack_switch = res_q.stack_sw;
  assign entry_off    = res_q.entry_off;
  assign param_cnt    = res_q.param_cnt;
  assign new_cs_sel   = res_q.new_cs;

endmodule

// File: rtl/ctpc_xfer_check_sva.sv
module ctpc_xfer_check_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [1:0]  cur_cpl,
  input logic        rsp_valid,
  input logic        allow,
  input logic [2:0]  fault_code,
  input logic [1:0]  xfer_kind,
  input logic [1:0]  new_cpl,
  input logic        stack_switch,
  input logic [31:0] entry_off,
  input logic [4:0]  param_cnt,
  input logic [15:0] new_cs_sel
);

  assert_resp_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_resp_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  assert_result_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(allow) && $stable(fault_code) && $stable(xfer_kind) &&
                    $stable(new_cpl) && $stable(entry_off) && $stable(new_cs_sel)));

  assert_allow_vs_fault_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (allow == (fault_code == 3'd0)));

  assert_fault_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (allow || (entry_off == 32'h0 && param_cnt == 5'd0 &&
                             !stack_switch && new_cs_sel == 16'h0 &&
                             new_cpl == $past(cur_cpl))));

  assert_stack_switch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (stack_switch == (allow && (new_cpl < $past(cur_cpl)))));

  assert_inner_kind_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (stack_switch == (xfer_kind == 2'd2)));

  assert_direct_keeps_cpl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (!(allow && xfer_kind == 2'd0) || new_cpl == $past(cur_cpl)));

  assert_never_outward_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (new_cpl <= $past(cur_cpl)));

endmodule

bind ctpc_xfer_check ctpc_xfer_check_sva u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .cur_cpl      (cur_cpl),
  .rsp_valid    (rsp_valid),
  .allow        (allow),
  .fault_code   (fault_code),
  .xfer_kind    (xfer_kind),
  .new_cpl      (new_cpl),
  .stack_switch (stack_switch),
  .entry_off    (entry_off),
  .param_cnt    (param_cnt),
  .new_cs_sel   (new_cs_sel)
);

// File: tb/ctpc_xfer_check_tb.sv
module ctpc_xfer_check_tb;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  cur_cpl;
  logic [15:0] req_sel;
  logic [31:0] req_off;
  logic [63:0] desc_pri;
  logic [63:0] desc_tgt;
  logic        rsp_valid;
  logic        allow;
  logic [2:0]  fault_code;
  logic [1:0]  xfer_kind;
  logic [1:0]  new_cpl;
  logic        stack_switch;
  logic [31:0] entry_off;
  logic [4:0]  param_cnt;
  logic [15:0] new_cs_sel;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  ctpc_xfer_check u_dut (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .cur_cpl (cur_cpl),
    .req_sel (req_sel), .req_off (req_off), .desc_pri (desc_pri), .desc_tgt (desc_tgt),
    .rsp_valid (rsp_valid), .allow (allow), .fault_code (fault_code),
    .xfer_kind (xfer_kind), .new_cpl (new_cpl), .stack_switch (stack_switch),
    .entry_off (entry_off), .param_cnt (param_cnt), .new_cs_sel (new_cs_sel)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // descriptor image: {off_hi, P, DPL, S, type, 3'b0, count, low word}
  function automatic logic [63:0] mk(input logic p, input logic [1:0] dpl, input logic s,
                                     input logic [3:0] t, input logic [15:0] hi,
                                     input logic [4:0] cnt, input logic [31:0] lo);
    return {hi, p, dpl, s, t, 3'b000, cnt, lo};
  endfunction

  // expected {allow, fault, kind, cpl, stack, offset, count, selector}
  function automatic logic [61:0] model(input logic [1:0] cpl, input logic [15:0] sel,
                                        input logic [63:0] pd, input logic [63:0] ad,
                                        input logic [31:0] off);
    logic [2:0]  f;
    logic [1:0]  k, nc, e, pdl, adl;
    logic        sw, pp, ps, ap, as_;
    logic [3:0]  pt, at;
    logic [31:0] eo;
    logic [4:0]  pc;
    logic [15:0] cs;
    pp = pd[47]; pdl = pd[46:45]; ps = pd[44]; pt = pd[43:40];
    ap = ad[47]; adl = ad[46:45]; as_ = ad[44]; at = ad[43:40];
    e  = (sel[1:0] > cpl) ? sel[1:0] : cpl;
    f = 3'd0; k = 2'd0; nc = cpl; sw = 1'b0; eo = 32'h0; pc = 5'd0; cs = 16'h0;
    if (ps && pt[3]) begin
      if (!pp) f = 3'd3;
      else if (pt[2] ? (pdl > cpl) : (pdl != cpl)) f = 3'd1;
      else begin eo = off; cs = {sel[15:2], cpl}; end
    end else if (!ps && pt[2:0] == 3'b100) begin
      if (!pp) f = 3'd3;
      else if (e > pdl) f = 3'd1;
      else if (!(as_ && at[3])) f = 3'd2;
      else if (!ap) f = 3'd3;
      else if (adl > cpl) f = 3'd1;
      else begin
        nc = at[2] ? cpl : adl;
        sw = (nc < cpl);
        k  = sw ? 2'd2 : 2'd1;
        eo = pt[3] ? {pd[63:48], pd[15:0]} : {16'h0, pd[15:0]};
        pc = pd[36:32];
        cs = {pd[31:18], nc};
      end
    end else if (!ps && pt == 4'b0101) begin
      if (!pp) f = 3'd3;
      else if (e > pdl) f = 3'd1;
      else if (!(!as_ && !at[2] && at[0])) f = 3'd2;
      else if (!ap) f = 3'd3;
      else if (at[1]) f = 3'd4;
      else k = 2'd3;
    end else if (!ps && !pt[2] && pt[0]) begin
      if (!pp) f = 3'd3;
      else if (pdl != cpl) f = 3'd1;
      else if (pt[1]) f = 3'd4;
      else k = 2'd3;
    end else begin
      f = 3'd2;
    end
    return {(f == 3'd0), f, k, nc, sw, eo, pc, cs};
  endfunction

  function automatic logic [61:0] observed();
    return {allow, fault_code, xfer_kind, new_cpl, stack_switch, entry_off, param_cnt, new_cs_sel};
  endfunction

  task automatic check(input string tag, input logic [61:0] act, input logic [61:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one request, answer sampled on the following falling edge
  task automatic run(input string tag, input logic [1:0] cpl, input logic [15:0] sel,
                     input logic [63:0] pd, input logic [63:0] ad, input logic [31:0] off);
    logic [61:0] exp;
    exp = model(cpl, sel, pd, ad, off);
    @(negedge clk);
    cur_cpl = cpl; req_sel = sel; desc_pri = pd; desc_tgt = ad; req_off = off;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(tag, {observed(), 1'b0}, {exp, 1'b0});
    if (rsp_valid !== 1'b1) begin
      n_fail++;
      $display("FAIL R1: rsp_valid actual %b expected 1", rsp_valid);
    end
    n_checks++;
  endtask

  initial begin
    int cycles = 0;
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
      end
    end
  end

  initial begin
    logic [61:0] held;
    rst_n = 1'b0; req_valid = 1'b0; cur_cpl = 2'd0; req_sel = 16'h0;
    req_off = 32'h0; desc_pri = 64'h0; desc_tgt = 64'h0;
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 reset", {observed(), rsp_valid}, 63'h0);
    rst_n = 1'b1;

    // R4 R5 R3: direct code segments
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        for (int d = 0; d < 4; d++)
          for (int cf = 0; cf < 2; cf++)
            for (int p = 0; p < 2; p++)
              run(cf ? "R5 conforming" : (p ? "R4 direct" : "R3 absent code"),
                  2'(c), {12'h4F3, 2'(d), 2'(r)},
                  mk(1'(p), 2'(d), 1'b1, {1'b1, 1'(cf), 2'b11}, 16'h00AB, 5'd0, 32'h7B3E_3EA0),
                  64'h0, 32'hA000_0000 + 32'(c * 64 + r * 16 + d * 4 + cf * 2 + p));

    // R6 R7 R8: call gates, gate selector carrying nonzero RPL bits
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        for (int gd = 0; gd < 4; gd++)
          for (int td = 0; td < 4; td++)
            for (int cf = 0; cf < 2; cf++)
              run("R6 R7 R8 call gate", 2'(c), {12'h006, 2'b00, 2'(r)},
                  mk(1'b1, 2'(gd), 1'b0, {1'((c + td) % 2), 3'b100}, 16'hBEEF,
                     5'(c * 8 + td * 2 + cf), {14'h0054, 2'(td ^ 2'b11), 16'h3400}),
                  mk(1'b1, 2'(td), 1'b1, {1'b1, 1'(cf), 2'b01}, 16'h0, 5'd0, 32'h1BCC_EE3D),
                  32'h0);

    // R3 R11: gate faults and fault priority
    run("R3 gate absent", 2'd3, 16'h0063, mk(1'b0, 2'd3, 1'b0, 4'hC, 16'h1, 5'd2, 32'h0150_3400),
        mk(1'b1, 2'd0, 1'b1, 4'h9, 16'h0, 5'd0, 32'h0), 32'h0);
    run("R3 gate target absent", 2'd3, 16'h0063, mk(1'b1, 2'd3, 1'b0, 4'hC, 16'h1, 5'd2, 32'h0150_3400),
        mk(1'b0, 2'd0, 1'b1, 4'h9, 16'h0, 5'd0, 32'h0), 32'h0);
    run("R6 gate target data", 2'd3, 16'h0063, mk(1'b1, 2'd3, 1'b0, 4'hC, 16'h1, 5'd2, 32'h0150_3400),
        mk(1'b1, 2'd0, 1'b1, 4'h3, 16'h0, 5'd0, 32'h0), 32'h0);
    run("R11 absent before type", 2'd3, 16'h0063, mk(1'b0, 2'd3, 1'b0, 4'hC, 16'h1, 5'd2, 32'h0150_3400),
        mk(1'b0, 2'd0, 1'b1, 4'h3, 16'h0, 5'd0, 32'h0), 32'h0);
    run("R11 gate priv before target type", 2'd3, 16'h0063, mk(1'b1, 2'd1, 1'b0, 4'hC, 16'h1, 5'd2, 32'h0150_3400),
        mk(1'b0, 2'd0, 1'b1, 4'h3, 16'h0, 5'd0, 32'h0), 32'h0);
    run("R11 target type before absent", 2'd0, 16'h0060, mk(1'b1, 2'd3, 1'b0, 4'hC, 16'h1, 5'd2, 32'h0150_3400),
        mk(1'b0, 2'd0, 1'b0, 4'h9, 16'h0, 5'd0, 32'h0), 32'h0);

    // R10: task gates over every privilege pairing, busy and not
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        for (int gd = 0; gd < 4; gd++)
          for (int td = 0; td < 4; td++)
            for (int b = 0; b < 2; b++)
              run("R10 task gate", 2'(c), {14'h0100, 2'(r)},
                  mk(1'b1, 2'(gd), 1'b0, 4'b0101, 16'h0, 5'd0, 32'h0028_0000),
                  mk(1'b1, 2'(td), 1'b0, {1'(td % 2), 1'b0, 1'(b), 1'b1}, 16'h0, 5'd0, 32'h0),
                  32'h55);
    run("R10 task gate to code", 2'd0, 16'h0100, mk(1'b1, 2'd3, 1'b0, 4'b0101, 16'h0, 5'd0, 32'h0),
        mk(1'b1, 2'd0, 1'b1, 4'hA, 16'h0, 5'd0, 32'h0), 32'h0);
    run("R10 task gate TSS absent", 2'd0, 16'h0100, mk(1'b1, 2'd3, 1'b0, 4'b0101, 16'h0, 5'd0, 32'h0),
        mk(1'b0, 2'd0, 1'b0, 4'h9, 16'h0, 5'd0, 32'h0), 32'h0);
    run("R11 task absent before busy", 2'd0, 16'h0100, mk(1'b1, 2'd3, 1'b0, 4'b0101, 16'h0, 5'd0, 32'h0),
        mk(1'b0, 2'd0, 1'b0, 4'hB, 16'h0, 5'd0, 32'h0), 32'h0);

    // R9: direct task state descriptors
    for (int c = 0; c < 4; c++)
      for (int d = 0; d < 4; d++)
        for (int b = 0; b < 2; b++)
          for (int p = 0; p < 2; p++)
            for (int w = 0; w < 2; w++)
              run("R9 direct TSS", 2'(c), {14'h0200, 2'(c)},
                  mk(1'(p), 2'(d), 1'b0, {1'(w), 1'b0, 1'(b), 1'b1}, 16'h0, 5'd0, 32'h0),
                  64'h0, 32'h99);

    // R2: every system type and every data segment type as first descriptor
    for (int t = 0; t < 16; t++)
      for (int s = 0; s < 2; s++)
        run("R2 type decode", 2'd0, 16'h0008,
            mk(1'b1, 2'd3, 1'(s), 4'(t), 16'h1234, 5'd3, 32'h0008_5678),
            mk(1'b1, 2'd0, 1'b1, 4'h8, 16'h0, 5'd0, 32'h0), 32'h0000_0100);

    // R1: result holds while no request; changed inputs have no effect
    run("R1 setup", 2'd3, 16'h0063, mk(1'b1, 2'd3, 1'b0, 4'hC, 16'h0000, 5'd2, 32'h0150_3400),
        mk(1'b1, 2'd0, 1'b1, 4'h9, 16'h0, 5'd0, 32'h0), 32'h0);
    held = observed();
    for (int i = 0; i < 4; i++) begin
      cur_cpl = 2'(i); req_sel = 16'hFFFF; desc_pri = 64'h0; desc_tgt = 64'hFFFF_FFFF_FFFF_FFFF;
      @(negedge clk);
      check("R1 hold", {observed(), rsp_valid}, {held, 1'b0});
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule